// File: doc/BRIEF.md
# Hyperprivileged Control Register Bank

This block holds the control state a hypervisor keeps per strand. It contains a trap base address register, a fixed version word, a hyperprivileged state word, a trap-state word and head/tail pointer pairs for four interrupt queues. From that state it derives four registered interrupt request lines:

- one for each of the CPU-mondo, device-mondo and resumable-error queues, raised while the queue holds entries;
- a trap-level-zero request built from the state word and the current trap level.

Software reaches the bank through a single-cycle indexed access port. A request is a one-cycle strobe on `acc_en` and is always accepted, so the port has no back-pressure. Exactly one clock later `rsp_valid` pulses, carrying the read data and an error flag. The port carries control rather than streamed data, so it uses no valid/ready handshake.

Index map:

| Index | Register |
|-------|----------|
| 0 | trap base address |
| 1 | version |
| 2 | hyperprivileged state |
| 3 | trap state |
| 4 | CPU-mondo queue head |
| 5 | CPU-mondo queue tail |
| 6 | device-mondo queue head |
| 7 | device-mondo queue tail |
| 8 | resumable-error queue head |
| 9 | resumable-error queue tail |
| 10 | non-resumable-error queue head |
| 11 | non-resumable-error queue tail |
| 12 to 15 | unused |

Hyperprivileged state bit positions:

| Bit | Meaning |
|-----|---------|
| 0 | trap-level-zero enable |
| 2 | hyperprivileged mode |
| 11 | implementation identifier |

Top module: `hpcr_bank`

## Requirements
- R1: A write to index 0 stores the data with bits 14..0 cleared; a read of index 0 returns bits 14..0 as zero and the upper bits as written.
- R2: A read of index 1 returns NWIN | (MAXTL << 8) | (MAXGL << 16), which is 0x030608 with the defaults 8, 6 and 3. A write to index 1 sets `rsp_err`, returns data zero, and leaves the value read afterwards unchanged.
- R3: Every write to index 2 stores the data with bit 11 forced to 1; all other bits are stored as written.
- R4: `irq_tlz` is 1 exactly when, at the previous clock edge, index 2 bit 0 was 1, bit 2 was 0 and `trap_lvl` was 0.
- R5: For queues 0 (CPU mondo), 1 (device mondo) and 2 (resumable error), `irq_queue[q]` is 1 exactly when that queue's head differs from its tail. The comparison is redone after a write to either pointer.
- R6: Queue 3 (non-resumable error) stores its head and tail as written, but `irq_queue[3]` stays 0 whatever their values.
- R7: An access to index 12 through 15 sets `rsp_err`, returns data zero and changes no register or interrupt output.
- R8: After reset every queue pointer and the trap base are zero, index 2 reads 0x800, `rsp_valid` is low and every interrupt output is low.
- R9: `rsp_valid` pulses in the cycle after `acc_en`. An interrupt output reflects a register write one clock after the edge that performs the write, and not at that edge.
- R10: Index 3 stores and returns all 64 bits as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, accepted every cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 4 | Register index |
| acc_wdata | input | 64 | Write data |
| trap_lvl | input | 3 | Current trap level |
| rsp_valid | output | 1 | Response strobe, one cycle after `acc_en` |
| rsp_err | output | 1 | Unknown index, or write to the version register |
| rsp_rdata | output | 64 | Read data; zero on error and on writes |
| irq_queue | output | 4 | Queue non-empty requests; bit 3 is always 0 |
| irq_tlz | output | 1 | Trap-level-zero request |

## Verification
A pointer register that is wrongly held or corrupted shows up on `irq_queue` one clock after the write, and in the data of the next read of that index. A lost mask or forced bit in the trap base or state word appears in the very next read response. A fault in the trap-level-zero logic appears on `irq_tlz` one edge after `trap_lvl` or the state word changes. Every scenario therefore samples both the cycle right after the write edge, when outputs must not yet move, and the cycle after that.

// File: rtl/hpcr_pkg.sv
package hpcr_pkg;
  localparam int IDX_W     = 4;
  localparam int QBASE     = 4;
  localparam int HTBA_CLR  = 15;
  localparam int HS_TLZ    = 0;
  localparam int HS_HPRIV  = 2;
  localparam int HS_ID     = 11;

  typedef enum logic [IDX_W-1:0] {
    IX_HTBA    = 4'd0,
    IX_VER     = 4'd1,
    IX_HSTATE  = 4'd2,
    IX_HTSTATE = 4'd3
  } fixed_idx_e;
endpackage

// File: rtl/hpcr_decode.sv
module hpcr_decode
  import hpcr_pkg::*;
#(
  parameter int NUM_Q = 4
) (
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] acc_idx,
  output logic             wr_htba,
  output logic             wr_hstate,
  output logic             wr_htstate,
  output logic [NUM_Q-1:0] wr_head,
  output logic [NUM_Q-1:0] wr_tail,
  output logic             acc_bad
);
  localparam int LAST_IDX = QBASE + 2*NUM_Q - 1;

  logic known;
  logic wr_ok;

  assign known      = int'(acc_idx) <= LAST_IDX;
  assign acc_bad    = acc_en && (!known || (acc_wr && acc_idx == IX_VER));
  assign wr_ok      = acc_en && acc_wr && known;
  assign wr_htba    = wr_ok && (acc_idx == IX_HTBA);
  assign wr_hstate  = wr_ok && (acc_idx == IX_HSTATE);
  assign wr_htstate = wr_ok && (acc_idx == IX_HTSTATE);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_qdec
    assign wr_head[q] = wr_ok && (int'(acc_idx) == QBASE + 2*q);
    assign wr_tail[q] = wr_ok && (int'(acc_idx) == QBASE + 2*q + 1);
  end
endmodule

// File: rtl/hpcr_queue_pair.sv
module hpcr_queue_pair #(
  parameter int DATA_W  = 64,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_head,
  input  logic              wr_tail,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [DATA_W-1:0] tail,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (wr_head) head <= wdata;
      if (wr_tail) tail <= wdata;
    end
  end

  if (HAS_IRQ) begin : g_irq
    // compares the pointers as they stand after any write, one edge later
    always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (head != tail);
    end
  end else begin : g_noirq
    assign irq = 1'b0;
  end
endmodule

// File: rtl/hpcr_state_regs.sv
module hpcr_state_regs
  import hpcr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_htba,
  input  logic              wr_hstate,
  input  logic              wr_htstate,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TL_W-1:0]   trap_lvl,
  output logic [DATA_W-1:0] htba,
  output logic [DATA_W-1:0] hstate,
  output logic [DATA_W-1:0] htstate,
  output logic              irq_tlz
);
  localparam logic [DATA_W-1:0] LOW_MASK = (DATA_W'(1) << HTBA_CLR) - DATA_W'(1);
  localparam logic [DATA_W-1:0] ID_BIT   = DATA_W'(1) << HS_ID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      htba    <= '0;
      hstate  <= ID_BIT;
      htstate <= '0;
      irq_tlz <= 1'b0;
    end else begin
      if (wr_htba)    htba    <= wdata & ~LOW_MASK;
      if (wr_hstate)  hstate  <= wdata | ID_BIT;
      if (wr_htstate) htstate <= wdata;
      irq_tlz <= hstate[HS_TLZ] && !hstate[HS_HPRIV] && (trap_lvl == '0);
    end
  end
endmodule

// File: rtl/hpcr_bank.sv
module hpcr_bank
  import hpcr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TL_W   = 3,
  parameter int NUM_Q  = 4,
  parameter logic [NUM_Q-1:0] QIRQ_EN = 4'b0111,
  parameter int NWIN   = 8,
  parameter int MAXTL  = 6,
  parameter int MAXGL  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [TL_W-1:0]   trap_lvl,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_Q-1:0]  irq_queue,
  output logic              irq_tlz
);
  localparam logic [DATA_W-1:0] VER_WORD =
      DATA_W'(NWIN) | (DATA_W'(MAXTL) << 8) | (DATA_W'(MAXGL) << 16);

  logic                           wr_htba, wr_hstate, wr_htstate, acc_bad;
  logic [NUM_Q-1:0]               wr_head, wr_tail;
  logic [DATA_W-1:0]              htba, hstate, htstate;
  logic [NUM_Q-1:0][DATA_W-1:0]   q_head, q_tail;
  logic [DATA_W-1:0]              rd_mux;

  hpcr_decode #(.NUM_Q(NUM_Q)) u_dec (
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_idx(acc_idx),
    .wr_htba(wr_htba), .wr_hstate(wr_hstate), .wr_htstate(wr_htstate),
    .wr_head(wr_head), .wr_tail(wr_tail), .acc_bad(acc_bad)
  );

  hpcr_state_regs #(.DATA_W(DATA_W), .TL_W(TL_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .wr_htba(wr_htba), .wr_hstate(wr_hstate), .wr_htstate(wr_htstate),
    .wdata(acc_wdata), .trap_lvl(trap_lvl),
    .htba(htba), .hstate(hstate), .htstate(htstate), .irq_tlz(irq_tlz)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    hpcr_queue_pair #(.DATA_W(DATA_W), .HAS_IRQ(QIRQ_EN[q])) u_qp (
      .clk(clk), .rst_n(rst_n),
      .wr_head(wr_head[q]), .wr_tail(wr_tail[q]), .wdata(acc_wdata),
      .head(q_head[q]), .tail(q_tail[q]), .irq(irq_queue[q])
    );
  end

  always_comb begin
    rd_mux = '0;
    if      (acc_idx == IX_HTBA)    rd_mux = htba;
    else if (acc_idx == IX_VER)     rd_mux = VER_WORD;
    else if (acc_idx == IX_HSTATE)  rd_mux = hstate;
    else if (acc_idx == IX_HTSTATE) rd_mux = htstate;
    for (int q = 0; q < NUM_Q; q++) begin
      if (int'(acc_idx) == QBASE + 2*q)     rd_mux = q_head[q];
      if (int'(acc_idx) == QBASE + 2*q + 1) rd_mux = q_tail[q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_en;
      if (acc_en) begin
        rsp_err   <= acc_bad;
        rsp_rdata <= (acc_bad || acc_wr) ? '0 : rd_mux;
      end
    end
  end
endmodule

// File: rtl/hpcr_bank_chk.sv
module hpcr_bank_chk
  import hpcr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TL_W   = 3,
  parameter int NUM_Q  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [IDX_W-1:0]  acc_idx,
  input logic [TL_W-1:0]   trap_lvl,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              irq_tlz
);
  localparam int LAST_IDX = QBASE + 2*NUM_Q - 1;

  p_htba_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_idx == IX_HTBA) |=> rsp_rdata[HTBA_CLR-1:0] == '0);

  p_ver_write_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_idx == IX_VER) |=> (rsp_err && rsp_rdata == '0));

  p_id_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_idx == IX_HSTATE) |=> rsp_rdata[HS_ID]);

  p_tlz_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tlz |-> $past(trap_lvl) == '0);

  p_bad_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && int'(acc_idx) > LAST_IDX) |=> (rsp_err && rsp_rdata == '0));

  p_good_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && int'(acc_idx) <= LAST_IDX) |=> !rsp_err);

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> rsp_valid);

  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !rsp_valid);
endmodule

bind hpcr_bank hpcr_bank_chk #(.DATA_W(DATA_W), .TL_W(TL_W), .NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_idx(acc_idx),
  .trap_lvl(trap_lvl), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .irq_tlz(irq_tlz)
);

// File: tb/hpcr_bank_bench.sv
module hpcr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [3:0]  acc_idx = '0;
  logic [63:0] acc_wdata = '0;
  logic [2:0]  trap_lvl = '0;
  logic        rsp_valid, rsp_err, irq_tlz;
  logic [63:0] rsp_rdata;
  logic [3:0]  irq_queue;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  hpcr_bank u_hpcr_bank (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .trap_lvl(trap_lvl),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .irq_queue(irq_queue), .irq_tlz(irq_tlz)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input int idx, input logic [63:0] d,
                        output logic [63:0] rd, output logic er);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_idx = 4'(idx); acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0;
    rd = rsp_rdata; er = rsp_err;
    check("R9 rsp_valid", 64'(rsp_valid), 64'd1);
  endtask

  task automatic t_reset();
    logic [63:0] rd; logic er;
    check("R8 irq_queue", 64'(irq_queue), 64'd0);
    check("R8 irq_tlz", 64'(irq_tlz), 64'd0);
    check("R8 rsp_valid", 64'(rsp_valid), 64'd0);
    access(1'b0, 0, '0, rd, er);  check("R8 htba", rd, 64'd0);
    access(1'b0, 2, '0, rd, er);  check("R8 hstate", rd, 64'h800);
    access(1'b0, 5, '0, rd, er);  check("R8 cpu tail", rd, 64'd0);
  endtask

  task automatic t_htba();
    logic [63:0] rd; logic er;
    access(1'b1, 0, '1, rd, er);
    access(1'b0, 0, '0, rd, er);
    check("R1 htba ones", rd, 64'hFFFF_FFFF_FFFF_8000);
    check("R1 err", 64'(er), 64'd0);
    access(1'b1, 0, 64'h1_2345, rd, er);
    access(1'b0, 0, '0, rd, er);
    check("R1 htba pattern", rd, 64'h1_0000);
  endtask

  task automatic t_ver();
    logic [63:0] rd; logic er;
    access(1'b0, 1, '0, rd, er);
    check("R2 ver read", rd, 64'h03_0608);
    access(1'b1, 1, 64'h55, rd, er);
    check("R2 ver write err", 64'(er), 64'd1);
    check("R2 ver write data", rd, 64'd0);
    access(1'b0, 1, '0, rd, er);
    check("R2 ver unchanged", rd, 64'h03_0608);
  endtask

  task automatic t_hstate();
    logic [63:0] rd; logic er;
    access(1'b1, 2, 64'h0, rd, er);
    access(1'b0, 2, '0, rd, er);
    check("R3 id forced", rd, 64'h800);
    access(1'b1, 2, 64'hA0_0004, rd, er);
    access(1'b0, 2, '0, rd, er);
    check("R3 other bits kept", rd, 64'hA0_0804);
  endtask

  task automatic t_tlz();
    logic [63:0] rd; logic er;
    trap_lvl = 3'd0;
    access(1'b1, 2, 64'h1, rd, er);
    check("R9 tlz not at write edge", 64'(irq_tlz), 64'd0);
    @(negedge clk);
    check("R4 tlz raised", 64'(irq_tlz), 64'd1);
    trap_lvl = 3'd1;
    @(negedge clk);
    check("R4 tlz nonzero level", 64'(irq_tlz), 64'd0);
    access(1'b1, 2, 64'h5, rd, er);
    trap_lvl = 3'd0;
    @(negedge clk);
    @(negedge clk);
    check("R4 tlz hpriv blocks", 64'(irq_tlz), 64'd0);
    access(1'b1, 2, 64'h0, rd, er);
  endtask

  task automatic t_queues();
    logic [63:0] rd; logic er;
    for (int q = 0; q < 3; q++) begin
      access(1'b1, 4 + 2*q + 1, 64'h40, rd, er);
      check("R9 irq not at write edge", 64'(irq_queue), 64'd0);
      @(negedge clk);
      check("R5 queue irq on tail", 64'(irq_queue), 64'(1 << q));
      access(1'b1, 4 + 2*q, 64'h40, rd, er);
      @(negedge clk);
      check("R5 queue irq cleared", 64'(irq_queue), 64'd0);
      access(1'b0, 4 + 2*q + 1, '0, rd, er);
      check("R5 tail readback", rd, 64'h40);
    end
  endtask

  task automatic t_nres();
    logic [63:0] rd; logic er;
    access(1'b1, 11, 64'h99, rd, er);
    @(negedge clk);
    @(negedge clk);
    check("R6 no irq", 64'(irq_queue), 64'd0);
    access(1'b0, 11, '0, rd, er);
    check("R6 tail stored", rd, 64'h99);
    access(1'b0, 10, '0, rd, er);
    check("R6 head stored", rd, 64'd0);
  endtask

  task automatic t_invalid();
    logic [63:0] rd; logic er;
    access(1'b0, 13, '0, rd, er);
    check("R7 read err", 64'(er), 64'd1);
    check("R7 read data", rd, 64'd0);
    access(1'b1, 15, '1, rd, er);
    check("R7 write err", 64'(er), 64'd1);
    @(negedge clk);
    check("R7 irqs untouched", 64'({irq_tlz, irq_queue}), 64'd0);
    access(1'b0, 2, '0, rd, er);
    check("R7 hstate untouched", rd, 64'h800);
    access(1'b0, 4, '0, rd, er);
    check("R7 head untouched", rd, 64'h40);
  endtask

  task automatic t_htstate();
    logic [63:0] rd; logic er;
    access(1'b1, 3, 64'hDEAD_BEEF_0123_4567, rd, er);
    access(1'b0, 3, '0, rd, er);
    check("R10 htstate", rd, 64'hDEAD_BEEF_0123_4567);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_htba();
    t_ver();
    t_hstate();
    t_tlz();
    t_queues();
    t_nres();
    t_invalid();
    t_htstate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule